// File: doc/BRIEF.md
# USB Full-Speed Bus Line-State Monitor

This block observes the two differential data lines of a full-speed USB port. The lines arrive already synchronized, and a strobe marks one sample per bit time. Each sample is classified as J, K, single-ended zero (SE0) or the illegal both-high pattern.

The block counts how many bit times each line condition has lasted. From those run lengths it tells apart end of packet, bus reset, disconnect, connect and suspend. It also recognizes start of packet and resume signalling. Results appear as one-cycle event pulses and as three level flags: connected, suspended and in-reset.

A single parameter selects how a long SE0 is read. On the device side it is a bus reset. On the hub or host side it is a disconnect.

Top module: `usb_line_monitor`

## Requirements
- R1: `line_o` shows the last strobed sample as {D+, D-}. The codes are 2'b00 for SE0, 2'b01 for K, 2'b10 for J and 2'b11 for illegal. Every event pulse and flag change appears in the clock cycle after the strobe cycle that caused it and lasts one clock. A cycle without a strobe produces no event.
- R2: While not connected, the sample that makes a run of legal non-SE0 samples (J or K) longer than `CONNECT_BITS` (default 30) pulses `connect_o` and sets `connected_o`.
- R3: A K sample whose previous legal sample was J pulses `sop_o`, provided no packet is open and the block is not suspended. A J-to-K change inside an open packet pulses nothing. A packet closes on any SE0 sample.
- R4: A J sample that follows a run of 1 to `EOP_MAX` (default 2) SE0 samples pulses `eop_o`.
- R5: A J sample after an SE0 run of 3 to 30 samples pulses no event.
- R6: With `HOST_VIEW`=0, the sample that makes an SE0 run longer than `RESET_BITS` (default 30) while connected pulses `bus_rst_o` and sets `in_reset_o`. The flag stays set through further SE0 and K samples and clears on the first J sample.
- R7: With `HOST_VIEW`=1, the same long SE0 pulses `disconnect_o` and clears `connected_o`. A later run of legal non-SE0 samples longer than `CONNECT_BITS` connects again.
- R8: While connected and not suspended, the sample that makes a J run longer than `SUSPEND_BITS` (default 36,000, which is 3 ms) pulses `suspend_o` and sets `suspended_o`.
- R9: A K sample while suspended pulses `resume_o` and clears `suspended_o`, with no `sop_o`.
- R10: An SE0 run longer than `RESET_BITS` clears `suspended_o`. On the device side it also signals a reset.
- R11: A both-high sample pulses `illegal_o` and sets `line_o` to 2'b11. It leaves the run counters and the previous legal state untouched, so an end of packet is still recognized across it.
- R12: After reset, every output is 0 and `line_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per bit time; the line levels are sampled when it is high |
| dp | input | 1 | Synchronized D+ level |
| dm | input | 1 | Synchronized D- level |
| line_o | output | 2 | Last sampled {D+, D-} |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| bus_rst_o | output | 1 | Bus reset detected (device view) |
| suspend_o | output | 1 | Suspend entry pulse |
| resume_o | output | 1 | Resume pulse |
| connect_o | output | 1 | Connect pulse |
| disconnect_o | output | 1 | Disconnect pulse (host view) |
| illegal_o | output | 1 | Both-lines-high sample pulse |
| suspended_o | output | 1 | Suspended flag |
| connected_o | output | 1 | Connected flag |
| in_reset_o | output | 1 | Bus reset in progress flag |

## Verification
The bench drives two instances from the same line stimulus: `uut` with `HOST_VIEW`=0 and `uut_h` with `HOST_VIEW`=1. This lets one sequence of long SE0 runs check reset and disconnect together. Both instances keep `CONNECT_BITS`=30 and `RESET_BITS`=30, but `SUSPEND_BITS` is lowered to 40. With that value, suspend entry, resume and wake by reset are all reached within a few hundred bit times, where the default would need tens of thousands.

// File: rtl/usb_line_monitor.sv
module usb_line_monitor #(
  parameter int CONNECT_BITS = 30,
  parameter int RESET_BITS   = 30,
  parameter int SUSPEND_BITS = 36000,
  parameter int EOP_MAX      = 2,
  parameter bit HOST_VIEW    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       dp,
  input  logic       dm,
  output logic [1:0] line_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       bus_rst_o,
  output logic       suspend_o,
  output logic       resume_o,
  output logic       connect_o,
  output logic       disconnect_o,
  output logic       illegal_o,
  output logic       suspended_o,
  output logic       connected_o,
  output logic       in_reset_o
);
  localparam int SEW = $clog2(RESET_BITS + 2);
  localparam int IW  = $clog2(SUSPEND_BITS + 2);
  localparam int AW  = $clog2(CONNECT_BITS + 2);
  localparam logic [SEW-1:0] SE0_TOP = SEW'(RESET_BITS + 1);
  localparam logic [IW-1:0]  IDL_TOP = IW'(SUSPEND_BITS + 1);
  localparam logic [AW-1:0]  ACT_TOP = AW'(CONNECT_BITS + 1);

  logic [SEW-1:0] se0_cnt;
  logic [IW-1:0]  idle_cnt;
  logic [AW-1:0]  act_cnt;
  logic           in_pkt;

  wire [1:0] smp    = {dp, dm};
  wire       is_se0 = smp == 2'b00;
  wire       is_k   = smp == 2'b01;
  wire       is_j   = smp == 2'b10;
  wire       is_bad = smp == 2'b11;

  wire long_se0  = bit_stb && is_se0 && se0_cnt == SEW'(RESET_BITS);
  wire hit_conn  = bit_stb && (is_j || is_k) && act_cnt == AW'(CONNECT_BITS) && !connected_o;
  wire hit_eop   = bit_stb && is_j && se0_cnt != '0 && se0_cnt <= SEW'(EOP_MAX);
  wire hit_sop   = bit_stb && is_k && idle_cnt != '0 && !in_pkt && !suspended_o;
  wire hit_susp  = bit_stb && is_j && idle_cnt == IW'(SUSPEND_BITS) && connected_o && !suspended_o;
  wire hit_res   = bit_stb && is_k && suspended_o;
  wire hit_rst   = long_se0 && connected_o && !HOST_VIEW;
  wire hit_disc  = long_se0 && connected_o && HOST_VIEW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_o       <= 2'b00;
      sop_o        <= 1'b0;
      eop_o        <= 1'b0;
      bus_rst_o    <= 1'b0;
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;
      connect_o    <= 1'b0;
      disconnect_o <= 1'b0;
      illegal_o    <= 1'b0;
      suspended_o  <= 1'b0;
      connected_o  <= 1'b0;
      in_reset_o   <= 1'b0;
      se0_cnt      <= '0;
      idle_cnt     <= '0;
      act_cnt      <= '0;
      in_pkt       <= 1'b0;
    end else begin
      sop_o        <= hit_sop;
      eop_o        <= hit_eop;
      bus_rst_o    <= hit_rst;
      suspend_o    <= hit_susp;
      resume_o     <= hit_res;
      connect_o    <= hit_conn;
      disconnect_o <= hit_disc;
      illegal_o    <= bit_stb && is_bad;

      if (bit_stb) line_o <= smp;

      if (bit_stb && !is_bad) begin
        se0_cnt  <= !is_se0 ? '0 : (se0_cnt == SE0_TOP ? se0_cnt : se0_cnt + 1'b1);
        idle_cnt <= !is_j   ? '0 : (idle_cnt == IDL_TOP ? idle_cnt : idle_cnt + 1'b1);
        act_cnt  <= is_se0  ? '0 : (act_cnt == ACT_TOP ? act_cnt : act_cnt + 1'b1);
      end

      if (hit_sop) in_pkt <= 1'b1;
      else if (bit_stb && is_se0) in_pkt <= 1'b0;

      if (hit_conn) connected_o <= 1'b1;
      else if (hit_disc) connected_o <= 1'b0;

      if (hit_susp) suspended_o <= 1'b1;
      else if (hit_res || long_se0) suspended_o <= 1'b0;

      if (hit_rst) in_reset_o <= 1'b1;
      else if (bit_stb && is_j) in_reset_o <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic [1:0] line_o,
  input logic       sop_o,
  input logic       eop_o,
  input logic       bus_rst_o,
  input logic       suspend_o,
  input logic       resume_o,
  input logic       connect_o,
  input logic       disconnect_o,
  input logic       illegal_o,
  input logic       suspended_o,
  input logic       connected_o,
  input logic       in_reset_o
);
  wire any_evt = sop_o | eop_o | bus_rst_o | suspend_o | resume_o |
                 connect_o | disconnect_o | illegal_o;

  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$past(bit_stb) |-> !any_evt); // R1
  AST_CONNECT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) connect_o |-> connected_o); // R2
  AST_SOP_ON_K: assert property (@(posedge clk) disable iff (!rst_n) sop_o |-> line_o == 2'b01); // R3
  AST_EOP_ON_J: assert property (@(posedge clk) disable iff (!rst_n) eop_o |-> line_o == 2'b10); // R4
  AST_RESET_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n) bus_rst_o |-> line_o == 2'b00 && in_reset_o); // R6
  AST_RESET_ENDS_ON_J: assert property (@(posedge clk) disable iff (!rst_n) in_reset_o |-> line_o != 2'b10); // R6
  AST_DISCONNECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n) disconnect_o |-> !connected_o && line_o == 2'b00); // R7
  AST_SUSPEND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(suspended_o) |-> suspend_o); // R8
  AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (!rst_n) resume_o |-> !suspended_o && line_o == 2'b01 && !sop_o); // R9
  AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |-> line_o == 2'b11); // R11
endmodule

bind usb_line_monitor usb_line_monitor_chk chk (.*);

// File: tb/usb_line_monitor_test.sv
`timescale 1ns/1ps
module usb_line_monitor_test;
  logic clk = 1'b0;
  logic rst_n, bit_stb, dp, dm;
  always #2.5 clk = ~clk;

  localparam logic [6:0] E_SOP = 7'h01, E_EOP = 7'h02, E_RST = 7'h04, E_SUSP = 7'h08,
                         E_RES = 7'h10, E_CONN = 7'h20, E_ILL = 7'h40;
  localparam logic [1:0] H_CONN = 2'b01, H_DISC = 2'b10;

  logic [1:0] line_o, line_h;
  logic sop_o, eop_o, rst_o, susp_o, res_o, conn_o, disc_o, ill_o, suspd, connd, inrst;
  logic sop_h, eop_h, rst_h, susp_h, res_h, conn_h, disc_h, ill_h, suspd_h, connd_h, inrst_h;

  usb_line_monitor #(.SUSPEND_BITS(40), .HOST_VIEW(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .dp(dp), .dm(dm), .line_o(line_o),
    .sop_o(sop_o), .eop_o(eop_o), .bus_rst_o(rst_o), .suspend_o(susp_o), .resume_o(res_o),
    .connect_o(conn_o), .disconnect_o(disc_o), .illegal_o(ill_o), .suspended_o(suspd),
    .connected_o(connd), .in_reset_o(inrst));

  usb_line_monitor #(.SUSPEND_BITS(40), .HOST_VIEW(1'b1)) uut_h (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .dp(dp), .dm(dm), .line_o(line_h),
    .sop_o(sop_h), .eop_o(eop_h), .bus_rst_o(rst_h), .suspend_o(susp_h), .resume_o(res_h),
    .connect_o(conn_h), .disconnect_o(disc_h), .illegal_o(ill_h), .suspended_o(suspd_h),
    .connected_o(connd_h), .in_reset_o(inrst_h));

  int checks = 0, errors = 0;
  logic e_conn, e_susp, e_rst, h_conn;
  logic [14:0] expq[$];
  string tagq[$];

  wire [14:0] actual = {disc_h, conn_h, connd_h, ill_o, conn_o, res_o, susp_o, rst_o,
                        eop_o, sop_o, suspd, connd, inrst, line_o};

  task automatic compare(input logic [14:0] act, input logic [14:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic smp(input logic p, input logic m, input logic [6:0] ev,
                     input logic [1:0] hv, input string tag);
    @(negedge clk);
    dp = p; dm = m; bit_stb = 1'b1;
    expq.push_back({hv, h_conn, ev, e_susp, e_conn, e_rst, p, m});
    tagq.push_back(tag);
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic run(input int n, input logic p, input logic m, input string tag);
    for (int i = 0; i < n; i++) smp(p, m, 7'h0, 2'b00, tag);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bit_stb === 1'b1) begin
        @(negedge clk);
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL monitor actual %h expected none", actual);
        end else begin
          compare(actual, expq.pop_front(), tagq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; dp = 1'b0; dm = 1'b0;
    e_conn = 0; e_susp = 0; e_rst = 0; h_conn = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(actual, 15'h0, "R12");

    run(5, 0, 0, "R1");
    run(30, 1, 0, "R2");
    e_conn = 1; h_conn = 1;
    smp(1, 0, E_CONN, H_CONN, "R2");

    smp(0, 1, E_SOP, 0, "R3");
    smp(1, 0, 0, 0, "R3");
    smp(0, 1, 0, 0, "R3");
    smp(0, 1, 0, 0, "R3");
    smp(1, 0, 0, 0, "R3");
    run(2, 0, 0, "R4");
    smp(1, 0, E_EOP, 0, "R4");

    smp(0, 1, E_SOP, 0, "R3");
    smp(0, 0, 0, 0, "R4");
    smp(1, 0, E_EOP, 0, "R4");

    run(3, 0, 0, "R5");
    smp(1, 0, 0, 0, "R5");

    smp(0, 1, E_SOP, 0, "R3");
    run(2, 0, 0, "R11");
    smp(1, 1, E_ILL, 0, "R11");
    smp(1, 0, E_EOP, 0, "R11");

    run(30, 0, 0, "R6");
    e_rst = 1; h_conn = 0;
    smp(0, 0, E_RST, H_DISC, "R6");
    run(2, 0, 0, "R6");
    smp(0, 1, 0, 0, "R6");
    e_rst = 0;
    smp(1, 0, 0, 0, "R6");

    run(28, 1, 0, "R7");
    h_conn = 1;
    smp(1, 0, 0, H_CONN, "R7");
    run(10, 1, 0, "R8");
    e_susp = 1;
    smp(1, 0, E_SUSP, 0, "R8");

    run(3, 1, 0, "R9");
    e_susp = 0;
    smp(0, 1, E_RES, 0, "R9");
    smp(1, 0, 0, 0, "R9");
    smp(0, 1, E_SOP, 0, "R9");

    run(40, 1, 0, "R8");
    e_susp = 1;
    smp(1, 0, E_SUSP, 0, "R10");
    run(30, 0, 0, "R10");
    e_susp = 0; e_rst = 1; h_conn = 0;
    smp(0, 0, E_RST, H_DISC, "R10");
    e_rst = 0;
    smp(1, 0, 0, 0, "R10");

    repeat (4) @(negedge clk);
    if (expq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual %0d left expected 0", expq.size());
    end
    finish_up();
  end
endmodule